// File: doc/BRIEF.md
# NAND Read-Ahead and Write-Posting Buffer

This block decouples a fast host from a slow NAND-style memory on a single chip-select. It owns one 32-entry by 16-bit FIFO that serves one direction per run. In prefetch mode it keeps issuing device reads while the FIFO has room, and the host drains the FIFO. In posting mode the host fills the FIFO and the engine writes it out to the device. A run starts from a start pulse that carries a byte count, a direction, a chip-select number and a device width. The run ends when that many bytes have crossed the device side and the FIFO is settled.

The downstream request carries only the chip-select number and a direction bit. No address goes out, so software must open the page beforehand. Each request is one access of the device width, held until the access engine acknowledges it. Flow control to the host uses two signals. A level interrupt fires when the usable amount reaches a threshold. A DMA request line asks for a programmable burst of host transfers.

Top module: `nand_stream_buffer`

## Requirements
- R1: After reset the engine is idle: `busy`, `dev_req`, `irq` and `dma_req` are 0, and `fifo_level` and `remaining` are 0.
- R2: A `start` pulse in idle with a nonzero `total_bytes` loads `remaining`, latches direction, chip-select and width, and raises `busy`. A `start` while busy, or with `total_bytes` of 0, changes nothing.
- R3: `dev_req` is only high while busy. It carries the latched chip-select on `dev_cs` and `dev_write` (1 = posting, 0 = prefetch). It stays high with stable `dev_cs` and `dev_write` until the cycle in which `dev_ack` is high.
- R4: In prefetch mode a request is issued only while the FIFO is not full (level below 32). The host sees the FIFO head on `host_rdata`, in arrival order, and `host_pop` removes it.
- R5: In posting mode a request is issued only while the FIFO holds data. Bytes reach the device in the order the host pushed them.
- R6: With `dev_wide`=1 each access moves a whole entry of two bytes, low byte first in the stream. When only one byte remains, the access counts one byte and the prefetched entry's upper byte reads as 0.
- R7: With `dev_wide`=0 each access moves one byte on bits 7:0: first the entry's low byte, then its high byte. An odd final byte completes an entry alone. Its prefetched upper byte is 0, and in posting mode only the low byte is sent.
- R8: `remaining` drops by the bytes moved on each acknowledged access and holds at every other cycle of a run.
- R9: `busy` falls once `remaining` is 0 and, in prefetch mode, the host has emptied the FIFO. In posting mode, entries pushed beyond the byte count are discarded and the FIFO ends empty.
- R10: `irq` is registered. It is 1 while busy with a nonzero `irq_level` and the usable amount at least `irq_level`. The usable amount is the fill level in prefetch mode and the free space in posting mode.
- R11: `dma_req` rises, while busy with a nonzero `dma_burst`, once the usable amount is at least `dma_burst`. It stays high for exactly `dma_burst` host transfers, then goes low for at least one cycle before it is evaluated again.
- R12: A host push in prefetch mode, in idle or into a full FIFO, and a host pop in posting mode or from an empty FIFO, leave the FIFO untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a run |
| write_mode | input | 1 | 1 = posting, 0 = prefetch |
| target_cs | input | CS_W | Chip-select bound to the run |
| dev_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| total_bytes | input | CNT_W | Byte count of the run |
| irq_level | input | LVL_W | Interrupt threshold in entries (0 = off) |
| dma_burst | input | LVL_W | DMA burst in entries (0 = off) |
| host_push | input | 1 | Host writes an entry (posting) |
| host_wdata | input | DATA_W | Entry written by the host |
| host_pop | input | 1 | Host takes the head entry (prefetch) |
| host_rdata | output | DATA_W | FIFO head entry |
| dev_req | output | 1 | Access request to the access engine |
| dev_cs | output | CS_W | Chip-select of the request |
| dev_write | output | 1 | Direction of the request |
| dev_wdata | output | DATA_W | Write data of the request |
| dev_ack | input | 1 | Access completed |
| dev_rdata | input | DATA_W | Read data, valid with `dev_ack` |
| busy | output | 1 | A run is in progress |
| remaining | output | CNT_W | Bytes still to move on the device side |
| fifo_level | output | LVL_W | Entries in the FIFO |
| irq | output | 1 | Threshold interrupt |
| dma_req | output | 1 | DMA burst request |

## Verification
The bench runs odd byte counts on both device widths, where a wrong packer would lose the last byte, leak the device's junk upper byte, or take one access too many. It lets a prefetch run fill the FIFO with no host reads. An engine without backpressure would keep requesting and overwrite unread entries, and a wrong counter would show something other than 64 bytes gone. The DMA line is watched across the exact end of a burst: a design that forgets its burst count either never drops the line or drops it late. Posting runs push extra entries past the count, which a wrong end condition would leave stuck in the FIFO or send to the device.

// File: rtl/nsb_pkg.sv
package nsb_pkg;

    // Run controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no run
        ST_HOLD  = 2'd1,   // run active, waiting for FIFO room/data or count end
        ST_REQ   = 2'd2,   // access presented to the access engine
        ST_DRAIN = 2'd3    // count done, settling the FIFO
    } nsb_state_e;

endpackage

// File: rtl/nsb_fifo.sv
module nsb_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic          do_push, do_pop;

    assign do_push = push && (level != FULL_LVL);
    assign do_pop  = pop && (level != '0);
    assign head    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push && !clr) begin
            mem[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            level <= '0;
        end else if (clr) begin
            wp_q  <= '0;
            rp_q  <= '0;
            level <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST_IDX) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == LAST_IDX) ? '0 : rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/nsb_flow.sv
module nsb_flow #(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          wr_mode,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] irq_thr,
    input  logic [LW-1:0] dma_size,
    input  logic          xfer,
    output logic          irq,
    output logic          dma_req
);

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [LW-1:0] avail;
    logic [LW-1:0] cnt_q;
    logic          act_q;

    // Usable amount for the host: entries to read, or slots to write
    assign avail   = wr_mode ? (FULL_LVL - level) : level;
    assign dma_req = act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            act_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            irq <= busy && (irq_thr != '0) && (avail >= irq_thr);   // R10
            if (!busy || dma_size == '0) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else if (!act_q) begin
                act_q <= (avail >= dma_size);                        // R11
                cnt_q <= '0;
            end else if (xfer) begin
                if (cnt_q == dma_size - 1'b1) begin
                    act_q <= 1'b0;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/nand_stream_buffer.sv
module nand_stream_buffer
    import nsb_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 14,
    parameter int CS_W       = 3,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              write_mode,
    input  logic [CS_W-1:0]   target_cs,
    input  logic              dev_wide,
    input  logic [CNT_W-1:0]  total_bytes,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [LVL_W-1:0]  dma_burst,
    input  logic              host_push,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dev_req,
    output logic [CS_W-1:0]   dev_cs,
    output logic              dev_write,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              busy,
    output logic [CNT_W-1:0]  remaining,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              irq,
    output logic              dma_req
);

    localparam int HALF_W              = DATA_W / 2;
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
    localparam logic [HALF_W-1:0] ZERO_HALF = '0;

    nsb_state_e         state_q, state_d;
    logic               mode_q;        // 1 = posting
    logic               wide_q;
    logic [CS_W-1:0]    cs_q;
    logic [CNT_W-1:0]   rem_q;
    logic               half_q;        // narrow device: low half of entry done
    logic [HALF_W-1:0]  lo_q;

    logic               start_ok, accepting, can_go, ack, last_byte, entry_done;
    logic [1:0]         step;
    logic               push_ok, pop_ok, eng_push, eng_pop;
    logic               f_push, f_pop, f_clr;
    logic [DATA_W-1:0]  f_push_data, eng_push_data, f_head;
    logic [LVL_W-1:0]   level;

    // ---------------- control decode ----------------
    assign start_ok   = (state_q == ST_IDLE) && start && (total_bytes != '0);   // R2
    assign accepting  = (state_q == ST_HOLD) || (state_q == ST_REQ);
    assign ack        = (state_q == ST_REQ) && dev_ack;
    assign last_byte  = (rem_q == CNT_W'(1));
    assign step       = (wide_q && !last_byte) ? 2'd2 : 2'd1;                  // R6
    assign entry_done = wide_q || half_q || last_byte;                         // R7
    assign can_go     = mode_q ? (level != '0) : (level != FULL_LVL);          // R4 R5

    // Host side, each gated so misdirected transfers are dropped (R12)
    assign push_ok = accepting && mode_q && host_push && (level != FULL_LVL);
    assign pop_ok  = (state_q != ST_IDLE) && !mode_q && host_pop && (level != '0);

    // Engine side of the FIFO
    assign eng_push = ack && !mode_q && entry_done;
    assign eng_pop  = ack && mode_q && entry_done;

    always_comb begin
        if (wide_q) begin
            eng_push_data = last_byte ? {ZERO_HALF, dev_rdata[HALF_W-1:0]} : dev_rdata;
        end else if (half_q) begin
            eng_push_data = {dev_rdata[HALF_W-1:0], lo_q};
        end else begin
            eng_push_data = {ZERO_HALF, dev_rdata[HALF_W-1:0]};
        end
    end

    assign f_push      = push_ok || eng_push;
    assign f_push_data = mode_q ? host_wdata : eng_push_data;
    assign f_pop       = pop_ok || eng_pop;
    assign f_clr       = start_ok || ((state_q == ST_DRAIN) && mode_q);        // R9

    nsb_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (f_clr),
        .push      (f_push),
        .push_data (f_push_data),
        .pop       (f_pop),
        .head      (f_head),
        .level     (level)
    );

    nsb_flow #(
        .DEPTH (FIFO_DEPTH)
    ) flow_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .wr_mode  (mode_q),
        .level    (level),
        .irq_thr  (irq_level),
        .dma_size (dma_burst),
        .xfer     (push_ok || pop_ok),
        .irq      (irq),
        .dma_req  (dma_req)
    );

    // ---------------- state register and run context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            wide_q  <= 1'b0;
            cs_q    <= '0;
            rem_q   <= '0;
            half_q  <= 1'b0;
            lo_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok) begin
                mode_q <= write_mode;
                wide_q <= dev_wide;
                cs_q   <= target_cs;
                rem_q  <= total_bytes;
                half_q <= 1'b0;
            end else if (ack) begin
                rem_q <= rem_q - {{(CNT_W-2){1'b0}}, step};                    // R8
                if (!wide_q) begin
                    if (entry_done) begin
                        half_q <= 1'b0;
                    end else begin
                        half_q <= 1'b1;
                        lo_q   <= dev_rdata[HALF_W-1:0];
                    end
                end
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok) state_d = ST_HOLD;
            ST_HOLD: begin
                if (rem_q == '0)  state_d = ST_DRAIN;
                else if (can_go)  state_d = ST_REQ;
            end
            ST_REQ:   if (dev_ack) state_d = ST_HOLD;
            ST_DRAIN: if (mode_q || level == '0) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy       = (state_q != ST_IDLE);
        dev_req    = (state_q == ST_REQ);
        dev_cs     = cs_q;
        dev_write  = mode_q;
        remaining  = rem_q;
        fifo_level = level;
        host_rdata = f_head;
        if (wide_q) begin
            dev_wdata = f_head;
        end else begin
            dev_wdata = {ZERO_HALF, half_q ? f_head[DATA_W-1:HALF_W] : f_head[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/nsb_checker.sv
module nsb_checker #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 14,
    parameter int CS_W  = 3,
    parameter int LW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             dev_req,
    input logic             dev_ack,
    input logic             dev_write,
    input logic [CS_W-1:0]  dev_cs,
    input logic [LW-1:0]    fifo_level,
    input logic [CNT_W-1:0] remaining
);

    AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req |-> busy);                                                     // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_ack) |=> (dev_req && $stable(dev_cs) && $stable(dev_write))); // R3
    AST_READ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && !dev_write) |-> (fifo_level < LW'(DEPTH)));                // R4
    AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && dev_write) |-> (fifo_level != '0));                        // R5
    AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));                                             // R4
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(dev_req && dev_ack)) |=> (remaining == $past(remaining)));  // R8
    AST_COUNT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req && dev_ack) |=> (remaining < $past(remaining)));              // R8

endmodule

bind nand_stream_buffer nsb_checker #(
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W),
    .CS_W  (CS_W),
    .LW    (LVL_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .dev_req    (dev_req),
    .dev_ack    (dev_ack),
    .dev_write  (dev_write),
    .dev_cs     (dev_cs),
    .fifo_level (fifo_level),
    .remaining  (remaining)
);

// File: tb/nand_stream_buffer_tb_top.sv
`timescale 1ns/1ps
module nand_stream_buffer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, write_mode, dev_wide;
    logic [2:0]  target_cs;
    logic [13:0] total_bytes;
    logic [5:0]  irq_level, dma_burst;
    logic        host_push, host_pop;
    logic [15:0] host_wdata, host_rdata;
    logic        dev_req, dev_write, dev_ack;
    logic [2:0]  dev_cs;
    logic [15:0] dev_wdata, dev_rdata;
    logic        busy, irq, dma_req;
    logic [13:0] remaining;
    logic [5:0]  fifo_level;

    always #2.5 clk = ~clk;

    nand_stream_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .write_mode(write_mode),
        .target_cs(target_cs), .dev_wide(dev_wide), .total_bytes(total_bytes),
        .irq_level(irq_level), .dma_burst(dma_burst),
        .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .host_rdata(host_rdata),
        .dev_req(dev_req), .dev_cs(dev_cs), .dev_write(dev_write), .dev_wdata(dev_wdata),
        .dev_ack(dev_ack), .dev_rdata(dev_rdata),
        .busy(busy), .remaining(remaining), .fifo_level(fifo_level),
        .irq(irq), .dma_req(dma_req)
    );

    int n_chk = 0;
    int n_err = 0;
    int g_total, g_wide, g_mode, g_cs;
    int dev_left, dev_byte, pop_idx, push_idx, wcount;
    logic [7:0] wlog [0:1023];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 37 + 11);
    endfunction

    function automatic logic [15:0] exp_entry(input int i);
        logic [7:0] hi;
        hi = (2 * i + 1 < g_total) ? pat(2 * i + 1) : 8'h00;
        return {hi, pat(2 * i)};
    endfunction

    // Access engine model: random latency, one-cycle ack
    initial begin
        int wait_cnt;
        int stp;
        dev_ack   = 1'b0;
        dev_rdata = '0;
        wait_cnt  = 0;
        forever begin
            @(negedge clk);
            if (dev_ack) begin
                dev_ack = 1'b0;
            end else if (dev_req) begin
                if (wait_cnt == 0) begin
                    chk(dev_cs == 3'(g_cs), "R3 chip-select", dev_cs, g_cs);
                    chk(dev_write == 1'(g_mode), "R3 direction", dev_write, g_mode);
                    stp = (g_wide != 0 && dev_left >= 2) ? 2 : 1;
                    if (g_wide != 0)
                        dev_rdata = {(stp == 2) ? pat(dev_byte + 1) : 8'h5A, pat(dev_byte)};
                    else
                        dev_rdata = {8'hA5, pat(dev_byte)};
                    if (g_mode != 0 && wcount < 1023) begin
                        wlog[wcount] = dev_wdata[7:0];
                        wcount++;
                        if (stp == 2) begin
                            wlog[wcount] = dev_wdata[15:8];
                            wcount++;
                        end
                    end
                    dev_byte += stp;
                    dev_left -= stp;
                    dev_ack  = 1'b1;
                    wait_cnt = $urandom % 3;
                end else begin
                    wait_cnt--;
                end
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R9 watchdog actual=hung expected=idle");
        summary();
        $finish;
    end

    task automatic start_run(input int mode, input int wide, input int total,
                             input int cs, input int thr, input int burst);
        g_mode = mode; g_wide = wide; g_total = total; g_cs = cs;
        dev_left = total; dev_byte = 0; pop_idx = 0; push_idx = 0; wcount = 0;
        write_mode  = 1'(mode);
        dev_wide    = 1'(wide);
        total_bytes = 14'(total);
        target_cs   = 3'(cs);
        irq_level   = 6'(thr);
        dma_burst   = 6'(burst);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain_read(input int prob);
        while (busy) begin
            if (fifo_level != 0 && ($urandom % 100) < prob) begin
                chk(host_rdata == exp_entry(pop_idx), "R4 prefetch data", host_rdata, exp_entry(pop_idx));
                host_pop = 1'b1;
                pop_idx++;
            end else begin
                host_pop = 1'b0;
            end
            @(negedge clk);
        end
        host_pop = 1'b0;
    endtask

    task automatic finish_read();
        chk(pop_idx == (g_total + 1) / 2, "R9 entries read", pop_idx, (g_total + 1) / 2);
        chk(remaining == 0, "R8 count at end", remaining, 0);
        chk(fifo_level == 0, "R9 FIFO empty", fifo_level, 0);
    endtask

    task automatic feed_write(input int extra);
        int n;
        n = (g_total + 1) / 2 + extra;
        while (busy) begin
            if (push_idx < n && fifo_level != 6'd32 && ($urandom % 100) < 70) begin
                host_push  = 1'b1;
                host_wdata = {pat(2 * push_idx + 1), pat(2 * push_idx)};
                push_idx++;
            end else begin
                host_push = 1'b0;
            end
            @(negedge clk);
        end
        host_push = 1'b0;
    endtask

    task automatic finish_write();
        chk(wcount == g_total, "R5 bytes written", wcount, g_total);
        for (int k = 0; k < g_total && k < wcount; k++) begin
            if (g_wide != 0)
                chk(wlog[k] == pat(k), "R6 posted byte", wlog[k], pat(k));
            else
                chk(wlog[k] == pat(k), "R7 posted byte", wlog[k], pat(k));
        end
        chk(fifo_level == 0, "R9 extra entries discarded", fifo_level, 0);
        chk(remaining == 0, "R8 count at end", remaining, 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        rst_n = 1'b0; start = 1'b0; write_mode = 1'b0; dev_wide = 1'b0;
        target_cs = '0; total_bytes = '0; irq_level = '0; dma_burst = '0;
        host_push = 1'b0; host_pop = 1'b0; host_wdata = '0;
        g_total = 0; g_wide = 0; g_mode = 0; g_cs = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !dev_req && !irq && !dma_req, "R1 idle flags",
            {busy, dev_req, irq, dma_req}, 0);
        chk(fifo_level == 0 && remaining == 0, "R1 idle counts", fifo_level + remaining, 0);

        // R12 push in idle is dropped
        host_push = 1'b1; host_wdata = 16'hBEEF;
        @(negedge clk);
        host_push = 1'b0;
        chk(fifo_level == 0, "R12 idle push", fifo_level, 0);

        // R2 zero count start ignored
        start_run(0, 1, 0, 1, 0, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R2 zero count", busy, 0);

        // Prefetch backpressure, irq, dma, ignored start and push
        start_run(0, 1, 200, 5, 8, 4);
        repeat (300) @(negedge clk);
        chk(fifo_level == 6'd32, "R4 FIFO fills", fifo_level, 32);
        chk(dev_req == 1'b0, "R4 no request when full", dev_req, 0);
        chk(remaining == 14'd136, "R8 R6 count after fill", remaining, 136);
        chk(irq == 1'b1, "R10 irq over threshold", irq, 1);
        chk(dma_req == 1'b1, "R11 dma raised", dma_req, 1);
        host_push = 1'b1; host_wdata = 16'h1234;
        @(negedge clk);
        host_push = 1'b0;
        chk(fifo_level == 6'd32, "R12 push in prefetch", fifo_level, 32);
        total_bytes = 14'd50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(remaining == 14'd136 && busy, "R2 start while busy", remaining, 136);
        for (int i = 0; i < 4; i++) begin
            chk(host_rdata == exp_entry(pop_idx), "R4 prefetch data", host_rdata, exp_entry(pop_idx));
            host_pop = 1'b1;
            pop_idx++;
            @(negedge clk);
        end
        host_pop = 1'b0;
        chk(dma_req == 1'b0, "R11 dma drops after burst", dma_req, 0);
        @(negedge clk);
        chk(dma_req == 1'b1, "R11 dma re-evaluated", dma_req, 1);
        irq_level = 6'd40;
        repeat (2) @(negedge clk);
        chk(irq == 1'b0, "R10 irq below threshold", irq, 0);
        irq_level = 6'd8;
        drain_read(100);
        finish_read();

        // Odd counts, both widths
        start_run(0, 0, 7, 3, 0, 0); drain_read(60); finish_read();   // R7
        start_run(0, 1, 5, 6, 0, 0); drain_read(60); finish_read();   // R6

        // Posting: free-space irq and dma
        start_run(1, 1, 9, 2, 32, 4);
        repeat (2) @(negedge clk);
        chk(irq == 1'b1, "R10 posting free space", irq, 1);
        chk(dma_req == 1'b1, "R11 posting dma", dma_req, 1);
        host_pop = 1'b1;
        @(negedge clk);
        host_pop = 1'b0;
        chk(fifo_level == 0, "R12 pop in posting", fifo_level, 0);
        feed_write(0); finish_write();

        start_run(1, 0, 7, 4, 0, 0); feed_write(2); finish_write();   // R7 R9
        start_run(1, 1, 64, 7, 0, 0); feed_write(3); finish_write();  // R6 R9

        // Random runs
        for (int r = 0; r < 8; r++) begin
            int m, w, t, c;
            m = $urandom % 2; w = $urandom % 2; t = 1 + $urandom % 300; c = $urandom % 8;
            start_run(m, w, t, c, $urandom % 33, $urandom % 9);
            if (m != 0) begin
                feed_write($urandom % 3);
                finish_write();
            end else begin
                drain_read(30 + $urandom % 70);
                finish_read();
            end
            @(negedge clk);
            chk(busy == 1'b0 && dma_req == 1'b0, "R9 idle after run", busy, 0);
        end

        summary();
        $finish;
    end

endmodule